// File: doc/BRIEF.md
# Three-Channel Doorbell Mailbox

This block is a doorbell mailbox on an APB bus. It lets processors raise events for one another. It has three channels: a low-priority non-secure channel, a high-priority non-secure channel and a secure channel. Each channel keeps a 32-bit doorbell word. A sender raises single bits in the word, and the receiver lowers each bit once it has dealt with the event. Every channel drives one level interrupt toward the remote processor. That interrupt is high while any bit of the channel's word is set.

Each channel has a 0x20-byte slot in a 4 KB window. Channel c starts at byte c*0x20. Inside a slot, the status register is at +0x00 and can be read. The set register is at +0x08 and the clear register at +0x10; both are write-only and use write-1 semantics. Accesses complete with no wait states.

A non-secure access is one with `pprot_i[1]` equal to 1. Such an access to the secure channel's slot is refused: the read returns zero, the write is dropped and the error response is raised. If a set and a clear land on the same bit in the same cycle, the set takes priority, so no event is lost.

Top module: `dbell_mailbox`

## Requirements
- R1: After reset, all three doorbell words are zero and `irq_o` is 3'b000.
- R2: A write to a channel's set register (offset 0x08) ORs the write data into that channel's word. Zero bits of the data leave their bits unchanged.
- R3: A write to a channel's clear register (offset 0x10) clears each bit that is 1 in the write data. All other bits keep their value.
- R4: A read of the status register (offset 0x00) returns the channel's current word. Reads of the set or clear offsets, of any other offset inside a slot, and of addresses at or above 0x60 all return zero.
- R5: `irq_o[c]` is high exactly when channel c's word is nonzero. Bit 0 is the low-priority non-secure channel, bit 1 the high-priority non-secure channel and bit 2 the secure channel.
- R6: A non-secure access (`pprot_i[1]`=1) anywhere in 0x40–0x5F raises `pslverr_o` and reads as zero. A write of this kind leaves the secure word unchanged.
- R7: A secure access (`pprot_i[1]`=0) to the secure channel works normally. Accesses to channels 0 and 1 work with either protection value. Neither case raises `pslverr_o`.
- R8: `pready_o` is always 1. `pslverr_o` is high only in the access phase (`psel_i` and `penable_i` both high).
- R9: A setup-phase cycle (`psel_i`=1, `penable_i`=0) changes no doorbell word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | APB clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 12 | Byte address within the 4 KB window |
| pwdata_i | input | 32 | Write data |
| pprot_i | input | 3 | APB protection; bit 1 set marks a non-secure access |
| prdata_o | output | 32 | Read data, valid in the access phase |
| pready_o | output | 1 | Transfer ready, always 1 |
| pslverr_o | output | 1 | Error response for a refused secure access |
| irq_o | output | 3 | Per-channel doorbell interrupt |

## Verification
The properties assume that the master follows the APB protocol. Each transfer is one setup cycle followed by one access cycle, and at most one register access happens per clock, so a set and a clear never meet in the same cycle. The directed tasks drive every transfer through a single pair of read and write tasks that produce exactly this two-cycle shape. Only the setup-only test breaks that shape: it holds select without enable on purpose, and even there it never issues a second access in the same cycle.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  parameter int NUM_CH    = 3;
  parameter int WORD_W    = 32;
  parameter int ADDR_W    = 12;
  parameter int SLOT_W    = 5;            // 0x20-byte slot per channel
  parameter int SECURE_CH = NUM_CH - 1;
  localparam int CH_W     = ADDR_W - SLOT_W;

  localparam logic [SLOT_W-1:0] OFF_STATUS = 5'h00;
  localparam logic [SLOT_W-1:0] OFF_SET    = 5'h08;
  localparam logic [SLOT_W-1:0] OFF_CLR    = 5'h10;

  typedef enum logic [1:0] {
    REG_NONE,
    REG_STATUS,
    REG_SET,
    REG_CLR
  } reg_kind_e;
endpackage

// File: rtl/dbell_apb_decode.sv
module dbell_apb_decode
  import dbell_pkg::*;
(
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [2:0]        pprot_i,
  output logic [NUM_CH-1:0] ch_hit_o,
  output reg_kind_e         kind_o,
  output logic              sec_block_o
);
  logic [CH_W-1:0]   ch_idx;
  logic [SLOT_W-1:0] off;

  assign ch_idx = paddr_i[ADDR_W-1:SLOT_W];
  assign off    = paddr_i[SLOT_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
    assign ch_hit_o[c] = (ch_idx == CH_W'(c));
  end

  always_comb begin
    unique case (off)
      OFF_STATUS: kind_o = REG_STATUS;
      OFF_SET:    kind_o = REG_SET;
      OFF_CLR:    kind_o = REG_CLR;
      default:    kind_o = REG_NONE;
    endcase
  end

  // whole secure slot is closed to non-secure masters
  assign sec_block_o = pprot_i[1] && ch_hit_o[SECURE_CH];
endmodule

// File: rtl/dbell_channel.sv
module dbell_channel
  import dbell_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] set_i,
  input  logic [WORD_W-1:0] clr_i,
  output logic [WORD_W-1:0] word_o,
  output logic              irq_o
);
  logic [WORD_W-1:0] word_q;

  // set wins over clear on the same bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) word_q <= '0;
    else         word_q <= (word_q & ~clr_i) | set_i;
  end

  assign word_o = word_q;
  assign irq_o  = |word_q;
endmodule

// File: rtl/dbell_mailbox.sv
module dbell_mailbox
  import dbell_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [WORD_W-1:0] pwdata_i,
  input  logic [2:0]        pprot_i,
  output logic [WORD_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] ch_hit;
  reg_kind_e         kind;
  logic              sec_block;
  logic              acc, wr_ok, rd_ok;
  logic [WORD_W-1:0] word [NUM_CH];
  logic [WORD_W-1:0] rd_mux;

  dbell_apb_decode u_dec (
    .paddr_i     (paddr_i),
    .pprot_i     (pprot_i),
    .ch_hit_o    (ch_hit),
    .kind_o      (kind),
    .sec_block_o (sec_block)
  );

  assign acc   = psel_i && penable_i;
  assign wr_ok = acc && pwrite_i && !sec_block;
  assign rd_ok = acc && !pwrite_i && !sec_block && (kind == REG_STATUS);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [WORD_W-1:0] set_v, clr_v;
    assign set_v = (wr_ok && ch_hit[c] && kind == REG_SET) ? pwdata_i : '0;
    assign clr_v = (wr_ok && ch_hit[c] && kind == REG_CLR) ? pwdata_i : '0;

    dbell_channel u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_v),
      .clr_i  (clr_v),
      .word_o (word[c]),
      .irq_o  (irq_o[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (ch_hit[c]) rd_mux = word[c];
  end

  assign prdata_o  = rd_ok ? rd_mux : '0;
  assign pready_o  = 1'b1;
  assign pslverr_o = acc && sec_block;
endmodule

// File: rtl/dbell_mailbox_chk.sv
module dbell_mailbox_chk
  import dbell_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              psel_i,
  input logic              penable_i,
  input logic              pwrite_i,
  input logic [ADDR_W-1:0] paddr_i,
  input logic [WORD_W-1:0] pwdata_i,
  input logic [2:0]        pprot_i,
  input logic [WORD_W-1:0] prdata_o,
  input logic              pready_o,
  input logic              pslverr_o,
  input logic [NUM_CH-1:0] irq_o
);
  logic acc, ns_sec;
  assign acc    = psel_i && penable_i;
  assign ns_sec = acc && pprot_i[1] && (paddr_i[ADDR_W-1:SLOT_W] == CH_W'(SECURE_CH));

  p_err_phase_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_o |-> acc);

  p_ns_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ns_sec |-> pslverr_o);

  p_ns_rdz_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ns_sec && !pwrite_i) |-> (prdata_o == '0));

  p_ns_nowr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ns_sec && pwrite_i) |=> $stable(irq_o[SECURE_CH]));

  p_wr_only_rdz_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !pwrite_i && paddr_i[SLOT_W-1:0] != OFF_STATUS) |-> (prdata_o == '0));

  p_idle_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(acc && pwrite_i) |=> $stable(irq_o));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_set
    p_set_irq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (acc && pwrite_i && paddr_i[ADDR_W-1:SLOT_W] == CH_W'(c) &&
       paddr_i[SLOT_W-1:0] == OFF_SET && pwdata_i != '0 &&
       !(c == SECURE_CH && pprot_i[1])) |=> irq_o[c]);
  end
endmodule

bind dbell_mailbox dbell_mailbox_chk u_chk (.*);

// File: tb/dbell_mailbox_bench.sv
module dbell_mailbox_bench;
  logic        clk_i = 0, rst_ni = 0;
  logic        psel_i = 0, penable_i = 0, pwrite_i = 0;
  logic [11:0] paddr_i = '0;
  logic [31:0] pwdata_i = '0;
  logic [2:0]  pprot_i = '0;
  logic [31:0] prdata_o;
  logic        pready_o, pslverr_o;
  logic [2:0]  irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [2:0] SEC = 3'b000, NSEC = 3'b010;

  always #4 clk_i = ~clk_i;

  dbell_mailbox u_dbell_mailbox (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_wr(logic [11:0] a, logic [31:0] d, logic [2:0] p, output logic err);
    @(negedge clk_i);
    psel_i = 1; penable_i = 0; pwrite_i = 1; paddr_i = a; pwdata_i = d; pprot_i = p;
    @(negedge clk_i);
    penable_i = 1;
    #1 err = pslverr_o;
    @(negedge clk_i);
    psel_i = 0; penable_i = 0; pwrite_i = 0;
  endtask

  task automatic apb_rd(logic [11:0] a, logic [2:0] p, output logic [31:0] d, output logic err);
    @(negedge clk_i);
    psel_i = 1; penable_i = 0; pwrite_i = 0; paddr_i = a; pprot_i = p;
    @(negedge clk_i);
    penable_i = 1;
    #1 d = prdata_o; err = pslverr_o;
    @(negedge clk_i);
    psel_i = 0; penable_i = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic e;
    chk("R1 irq", 32'(irq_o), 0);
    for (int c = 0; c < 3; c++) begin
      apb_rd(12'(c*32), SEC, d, e);
      chk("R1 status", d, 0);
    end
  endtask

  task automatic t_set();
    logic [31:0] d; logic e;
    apb_wr(12'h008, 32'h0000_0011, NSEC, e);
    apb_rd(12'h000, NSEC, d, e);
    chk("R2 set", d, 32'h11);
    apb_wr(12'h008, 32'h0000_0100, SEC, e);
    apb_rd(12'h000, SEC, d, e);
    chk("R2 accumulate", d, 32'h111);
    chk("R5 irq ch0 only", 32'(irq_o), 32'b001);
  endtask

  task automatic t_clear();
    logic [31:0] d; logic e;
    apb_wr(12'h010, 32'h0000_0010, NSEC, e);
    apb_rd(12'h000, NSEC, d, e);
    chk("R3 clear one", d, 32'h101);
    apb_wr(12'h010, 32'h0, NSEC, e);
    apb_rd(12'h000, NSEC, d, e);
    chk("R3 zero data", d, 32'h101);
    apb_wr(12'h010, 32'h0000_0101, NSEC, e);
    apb_rd(12'h000, NSEC, d, e);
    chk("R3 clear all", d, 0);
    chk("R5 irq low", 32'(irq_o), 0);
  endtask

  task automatic t_readzero();
    logic [31:0] d; logic e;
    apb_wr(12'h028, 32'h8000_0000, NSEC, e);
    chk("R5 irq ch1", 32'(irq_o), 32'b010);
    apb_rd(12'h020, NSEC, d, e);
    chk("R4 status ch1", d, 32'h8000_0000);
    apb_rd(12'h028, NSEC, d, e);
    chk("R4 set reads 0", d, 0);
    apb_rd(12'h030, NSEC, d, e);
    chk("R4 clr reads 0", d, 0);
    apb_rd(12'h024, NSEC, d, e);
    chk("R4 hole reads 0", d, 0);
    apb_rd(12'h060, SEC, d, e);
    chk("R4 unmapped reads 0", d, 0);
  endtask

  task automatic t_secure();
    logic [31:0] d; logic e;
    apb_wr(12'h048, 32'h0000_00A5, SEC, e);
    chk("R7 sec wr no err", 32'(e), 0);
    apb_rd(12'h040, SEC, d, e);
    chk("R7 sec read", d, 32'hA5);
    chk("R7 sec rd no err", 32'(e), 0);
    chk("R5 irq ch2", 32'(irq_o[2]), 1);
    apb_rd(12'h040, NSEC, d, e);
    chk("R6 ns read zero", d, 0);
    chk("R6 ns read err", 32'(e), 1);
    apb_wr(12'h050, 32'hFFFF_FFFF, NSEC, e);
    chk("R6 ns clr err", 32'(e), 1);
    apb_wr(12'h048, 32'h0000_0F00, NSEC, e);
    chk("R6 ns set err", 32'(e), 1);
    apb_rd(12'h040, SEC, d, e);
    chk("R6 word kept", d, 32'hA5);
    apb_rd(12'h020, NSEC, d, e);
    chk("R7 ns ch1 no err", 32'(e), 0);
  endtask

  task automatic t_setup_only();
    logic [31:0] d; logic e;
    @(negedge clk_i);
    psel_i = 1; penable_i = 0; pwrite_i = 1; paddr_i = 12'h008; pwdata_i = 32'hFFFF; pprot_i = SEC;
    #1 chk("R8 no err in setup", 32'(pslverr_o), 0);
    chk("R8 ready", 32'(pready_o), 1);
    @(negedge clk_i);
    psel_i = 0; pwrite_i = 0;
    apb_rd(12'h000, SEC, d, e);
    chk("R9 setup no write", d, 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_set();
    t_clear();
    t_readzero();
    t_secure();
    t_setup_only();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule